// File: doc/BRIEF.md
# Distributed Refresh Scheduler with Power-Up Wake Sequence

This block keeps a 4096-row dynamic memory alive by issuing CAS-before-RAS refresh cycles spread evenly over the 64 ms retention period. That works out to one refresh every 15.6 µs. Because the memory generates the row address itself during these cycles, the block drives only the three strobes (row strobe, column strobe, write enable) and never touches the address lines. The strobes are active low.

After reset the block keeps all strobes high for a 200 µs settling pause. It then runs eight back-to-back wake refresh cycles on its own. Only after the last of these has finished its precharge does it raise `initDone`, and from then on the access sequencer may use the memory. In normal operation an interval timer adds one owed refresh per interval. The block raises `refReq` while it is idle and owes at least one refresh, and starts a cycle in the clock after the sequencer answers with `refGrant`. While the sequencer keeps a page open, refreshes pile up, up to a limit of eight. At that limit `refUrgent` tells the sequencer that it must close its page now.

All timings are parameters counted in clock cycles. The defaults suit a 125 MHz clock: 25000 cycles of pause, an interval of 1950 cycles, and per refresh cycle 1 cycle of column strobe lead, 8 cycles of row strobe low and 5 cycles of precharge. That gives 112 ns per cycle.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is active, rasN, casN and weN are 1, strobeOwn is 1, and initDone, refReq and refUrgent are 0.
- R2: After reset is released, all strobes stay high until casN first falls, exactly INIT_PAUSE_CYC clock edges after release.
- R3: Right after the pause, exactly WAKE_CYCLES refresh cycles run back to back without any grant. initDone rises at the edge that ends the last precharge, which is INIT_PAUSE_CYC + WAKE_CYCLES × (CAS_LEAD_CYC + RAS_LOW_CYC + PRECH_CYC) edges after release. refReq stays 0 while initDone is 0.
- R4: Every refresh cycle has the same shape. casN goes low while rasN is high and stays alone for CAS_LEAD_CYC cycles. rasN is then low for RAS_LOW_CYC cycles with casN held low throughout. Both rise on the same edge. Both then stay high for at least PRECH_CYC cycles before casN falls again.
- R5: weN is 1 in every cycle.
- R6: Once initDone is high, one refresh becomes owed every REFRESH_INTERVAL_CYC edges, the first at edge REFRESH_INTERVAL_CYC after initDone rose. refReq is 1 exactly when the block is idle (strobeOwn = 0) and owes at least one refresh.
- R7: A refGrant sampled while refReq is 1 makes casN low and strobeOwn 1 after that same edge. A refGrant sampled while refReq is 0 and the block is idle has no effect: casN stays 1 and strobeOwn stays 0.
- R8: The owed count saturates at OWED_MAX, and refUrgent is 1 exactly when the count equals OWED_MAX. Each completed normal cycle lowers the count by one at the edge that ends its precharge.
- R9: strobeOwn is 1 from the start of each cycle until its precharge ends. In idle it is 0.
- R10: An interval expiring on the same edge that a refresh completes leaves the owed count unchanged. Neither event is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refGrant | input | 1 | Sequencer hands over the strobes (page closed, precharged) |
| refReq | output | 1 | Block is idle and owes a refresh |
| refUrgent | output | 1 | Owed count at its limit; the open page must close |
| initDone | output | 1 | Pause and wake cycles finished; accesses allowed |
| strobeOwn | output | 1 | Block drives the strobes this cycle |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low (held high) |

## Verification
The assertions assume that the sequencer asserts refGrant only after its own page has been closed and precharged. They also assume that the sequencer takes the strobes back only while strobeOwn is low, so the block's first column strobe fall never meets a row strobe that another agent still holds. The stimulus respects these assumptions because the bench plays a sequencer with no memory traffic of its own. Its grant pattern alternates between long starvation, continuous grant and coin-flip grant, with segment lengths drawn from `$urandom` under a fixed seed. This exercises saturation, draining, grants while no refresh is owed, and interval expiries that coincide with the end of a refresh cycle.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_CAS_LEAD,
    ST_RAS_LOW,
    ST_PRECH
  } refState_e;

  typedef enum logic [1:0] {
    PH_CAS,
    PH_RAS,
    PH_PRE
  } phaseSel_e;

  // Strobes from the control FSM to the datapath counters
  typedef struct packed {
    logic      phaseLoad;
    phaseSel_e phaseSel;
    logic      owedDec;
    logic      wakeInc;
    logic      setInit;
  } ctrlStrobes_t;

endpackage

// File: rtl/cbr_refresh_dp.sv
module cbr_refresh_dp
  import cbr_refresh_pkg::*;
#(
  parameter int unsigned INIT_PAUSE_CYC       = 25000,
  parameter int unsigned REFRESH_INTERVAL_CYC = 1950,
  parameter int unsigned WAKE_CYCLES          = 8,
  parameter int unsigned OWED_MAX             = 8,
  parameter int unsigned CAS_LEAD_CYC         = 1,
  parameter int unsigned RAS_LOW_CYC          = 8,
  parameter int unsigned PRECH_CYC            = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strb,
  output logic         pauseDone,
  output logic         phaseDone,
  output logic         wakeLast,
  output logic         owedAny,
  output logic         owedFull,
  output logic         initDone
);

  function automatic int unsigned maxOf3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  localparam int PAUSE_W = $clog2(INIT_PAUSE_CYC + 1);
  localparam int INTV_W  = $clog2(REFRESH_INTERVAL_CYC + 1);
  localparam int WAKE_W  = $clog2(WAKE_CYCLES + 1);
  localparam int OWED_W  = $clog2(OWED_MAX + 1);
  localparam int PH_MAX  = maxOf3(CAS_LEAD_CYC, RAS_LOW_CYC, PRECH_CYC);
  localparam int PH_W    = $clog2(PH_MAX + 1);

  localparam logic [PAUSE_W-1:0] PAUSE_LAST = PAUSE_W'(INIT_PAUSE_CYC - 1);
  localparam logic [INTV_W-1:0]  INTV_LAST  = INTV_W'(REFRESH_INTERVAL_CYC - 1);
  localparam logic [WAKE_W-1:0]  WAKE_LAST  = WAKE_W'(WAKE_CYCLES - 1);
  localparam logic [OWED_W-1:0]  OWED_TOP   = OWED_W'(OWED_MAX);

  logic [PAUSE_W-1:0] pauseCnt;
  logic [INTV_W-1:0]  intvCnt;
  logic [WAKE_W-1:0]  wakeCnt;
  logic [OWED_W-1:0]  owedCnt;
  logic [PH_W-1:0]    phaseCnt;
  logic               tick;

  function automatic logic [PH_W-1:0] phaseLen(phaseSel_e sel);
    case (sel)
      PH_CAS:  return PH_W'(CAS_LEAD_CYC - 1);
      PH_RAS:  return PH_W'(RAS_LOW_CYC - 1);
      default: return PH_W'(PRECH_CYC - 1);
    endcase
  endfunction

  // Power-up pause: counts up once and holds at its last value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pauseCnt <= '0;
    end else if (pauseCnt != PAUSE_LAST) begin
      pauseCnt <= pauseCnt + PAUSE_W'(1);
    end
  end
  assign pauseDone = (pauseCnt == PAUSE_LAST);

  // Phase length counter for the strobe sequence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (strb.phaseLoad) begin
      phaseCnt <= phaseLen(strb.phaseSel);
    end else if (phaseCnt != '0) begin
      phaseCnt <= phaseCnt - PH_W'(1);
    end
  end
  assign phaseDone = (phaseCnt == '0);

  // Wake cycle count and init flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeCnt  <= '0;
      initDone <= 1'b0;
    end else begin
      if (strb.wakeInc) wakeCnt  <= wakeCnt + WAKE_W'(1);
      if (strb.setInit) initDone <= 1'b1;
    end
  end
  assign wakeLast = (wakeCnt == WAKE_LAST);

  // Distributed interval timer, running only after init
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intvCnt <= '0;
    end else if (initDone) begin
      intvCnt <= tick ? '0 : intvCnt + INTV_W'(1);
    end
  end
  assign tick = initDone && (intvCnt == INTV_LAST);

  // Owed refresh count, saturating at OWED_MAX
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      owedCnt <= '0;
    end else begin
      case ({tick, strb.owedDec})
        2'b10:   if (owedCnt != OWED_TOP) owedCnt <= owedCnt + OWED_W'(1);
        2'b01:   owedCnt <= owedCnt - OWED_W'(1);
        default: owedCnt <= owedCnt;
      endcase
    end
  end
  assign owedAny  = (owedCnt != '0);
  assign owedFull = (owedCnt == OWED_TOP);

  // R8
  owed_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    owedCnt <= OWED_TOP);

  // R8
  no_dec_when_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.owedDec |-> owedAny);

  // R10
  tick_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && strb.owedDec) |=> $stable(owedCnt));

  // R6
  tick_counts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !strb.owedDec && !owedFull) |=> (owedCnt == $past(owedCnt) + OWED_W'(1)));

  // R3
  init_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(initDone) |-> initDone);

endmodule

// File: rtl/cbr_refresh_ctl.sv
module cbr_refresh_ctl
  import cbr_refresh_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         refGrant,
  input  logic         pauseDone,
  input  logic         phaseDone,
  input  logic         wakeLast,
  input  logic         owedAny,
  input  logic         initDone,
  output ctrlStrobes_t strb,
  output logic         refReq,
  output logic         strobeOwn,
  output logic         rasN,
  output logic         casN,
  output logic         weN
);

  refState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_PAUSE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext     = state;
    strb.phaseLoad = 1'b0;
    strb.phaseSel  = PH_CAS;
    strb.owedDec   = 1'b0;
    strb.wakeInc   = 1'b0;
    strb.setInit   = 1'b0;
    case (state)
      ST_PAUSE: begin
        if (pauseDone) begin
          stateNext      = ST_CAS_LEAD;
          strb.phaseLoad = 1'b1;
        end
      end
      ST_IDLE: begin
        if (owedAny && refGrant) begin
          stateNext      = ST_CAS_LEAD;
          strb.phaseLoad = 1'b1;
        end
      end
      ST_CAS_LEAD: begin
        if (phaseDone) begin
          stateNext      = ST_RAS_LOW;
          strb.phaseLoad = 1'b1;
          strb.phaseSel  = PH_RAS;
        end
      end
      ST_RAS_LOW: begin
        if (phaseDone) begin
          stateNext      = ST_PRECH;
          strb.phaseLoad = 1'b1;
          strb.phaseSel  = PH_PRE;
        end
      end
      ST_PRECH: begin
        if (phaseDone) begin
          if (!initDone) begin
            strb.wakeInc = 1'b1;
            if (wakeLast) begin
              strb.setInit = 1'b1;
              stateNext    = ST_IDLE;
            end else begin
              stateNext      = ST_CAS_LEAD;
              strb.phaseLoad = 1'b1;
            end
          end else begin
            strb.owedDec = 1'b1;
            stateNext    = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_PAUSE;
    endcase
  end

  assign rasN      = (state != ST_RAS_LOW);
  assign casN      = !((state == ST_CAS_LEAD) || (state == ST_RAS_LOW));
  assign weN       = 1'b1;
  assign strobeOwn = (state != ST_IDLE);
  assign refReq    = (state == ST_IDLE) && owedAny;

  // R4
  cas_before_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (!casN && $past(!casN)));

  // R4
  cas_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> !casN);

  // R4
  joint_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> $rose(casN));

  // R4
  cas_fall_from_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> ($past(rasN) && $past(casN) && rasN));

  // R3
  req_after_init_chk: assert property (@(posedge clk) disable iff (!rstN)
    refReq |-> initDone);

  // R7
  grant_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !owedAny && refGrant) |=> (casN && !strobeOwn));

  // R7
  grant_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && refGrant) |=> (!casN && strobeOwn));

  // R9
  own_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!casN || !rasN) |-> strobeOwn);

endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
  import cbr_refresh_pkg::*;
#(
  parameter int unsigned INIT_PAUSE_CYC       = 25000,
  parameter int unsigned REFRESH_INTERVAL_CYC = 1950,
  parameter int unsigned WAKE_CYCLES          = 8,
  parameter int unsigned OWED_MAX             = 8,
  parameter int unsigned CAS_LEAD_CYC         = 1,
  parameter int unsigned RAS_LOW_CYC          = 8,
  parameter int unsigned PRECH_CYC            = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic refGrant,
  output logic refReq,
  output logic refUrgent,
  output logic initDone,
  output logic strobeOwn,
  output logic rasN,
  output logic casN,
  output logic weN
);

  ctrlStrobes_t strb;
  logic pauseDone, phaseDone, wakeLast, owedAny;

  cbr_refresh_dp #(
    .INIT_PAUSE_CYC      (INIT_PAUSE_CYC),
    .REFRESH_INTERVAL_CYC(REFRESH_INTERVAL_CYC),
    .WAKE_CYCLES         (WAKE_CYCLES),
    .OWED_MAX            (OWED_MAX),
    .CAS_LEAD_CYC        (CAS_LEAD_CYC),
    .RAS_LOW_CYC         (RAS_LOW_CYC),
    .PRECH_CYC           (PRECH_CYC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .pauseDone(pauseDone),
    .phaseDone(phaseDone),
    .wakeLast (wakeLast),
    .owedAny  (owedAny),
    .owedFull (refUrgent),
    .initDone (initDone)
  );

  cbr_refresh_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .refGrant (refGrant),
    .pauseDone(pauseDone),
    .phaseDone(phaseDone),
    .wakeLast (wakeLast),
    .owedAny  (owedAny),
    .initDone (initDone),
    .strb     (strb),
    .refReq   (refReq),
    .strobeOwn(strobeOwn),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN)
  );

endmodule

// File: tb/cbr_refresh_sched_test.sv
module cbr_refresh_sched_test;

  localparam int P = 50;   // pause
  localparam int I = 40;   // interval
  localparam int W = 8;    // wake cycles
  localparam int M = 8;    // owed limit
  localparam int L = 1;    // cas lead
  localparam int R = 8;    // ras low
  localparam int E = 5;    // precharge
  localparam int CYC = L + R + E;
  localparam int T0 = P + W * CYC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refGrant = 1'b0;
  logic refReq, refUrgent, initDone, strobeOwn, rasN, casN, weN;

  int vectors = 0;
  int miscompares = 0;
  int n = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cbr_refresh_sched #(
    .INIT_PAUSE_CYC(P), .REFRESH_INTERVAL_CYC(I), .WAKE_CYCLES(W),
    .OWED_MAX(M), .CAS_LEAD_CYC(L), .RAS_LOW_CYC(R), .PRECH_CYC(E)
  ) uut (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .refReq(refReq),
    .refUrgent(refUrgent), .initDone(initDone), .strobeOwn(strobeOwn),
    .rasN(rasN), .casN(casN), .weN(weN)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s at edge %0d: got %0d expected %0d", req, n, act, exp);
    end
  endtask

  function automatic int satInc(int v);
    return (v >= M) ? M : v + 1;
  endfunction

  // Pre-edge samples of the handshake
  logic grantAtEdge = 1'b0, reqAtEdge = 1'b0, ownAtEdge = 1'b0;
  always @(posedge clk) begin
    if (rstN) n <= n + 1;
    grantAtEdge <= refGrant;
    reqAtEdge   <= refReq;
    ownAtEdge   <= strobeOwn;
  end

  // Monitor and reference model of the owed count
  logic prevRas = 1'b1, prevCas = 1'b1;
  int casLowRun = 0, rasLowRun = 0, highRun = 0, precLeft = 0;
  int cbrCount = 0, expOwed = 0, decEdge = -1, t0 = 0;

  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit tick, dec;
      chk(weN == 1'b1, "R5 weN high", weN, 1);
      if (n < P) chk(rasN && casN, "R2 strobes high in pause", {rasN, casN}, 3);
      if (!initDone) chk(refReq == 1'b0, "R3 no request before init", refReq, 0);

      if (!rasN && prevRas) chk(casLowRun == L, "R4 cas lead length", casLowRun, L);
      if (!rasN) begin
        chk(!casN, "R4 cas held while ras low", casN, 0);
        rasLowRun++;
      end
      if (rasN && !prevRas) begin
        chk(rasLowRun == R && casN, "R4 ras low length and joint rise", rasLowRun, R);
        rasLowRun = 0;
        cbrCount++;
        precLeft = E;
        if (initDone) decEdge = n + E;
      end
      if (precLeft > 0) begin
        chk(strobeOwn, "R9 own during precharge", strobeOwn, 1);
        precLeft--;
      end
      if (!casN && rasN) casLowRun++;
      else if (casN) casLowRun = 0;
      if (!casN && prevCas) begin
        chk(highRun >= E && strobeOwn, "R4 precharge before cas fall", highRun, E);
        highRun = 0;
      end
      if (rasN && casN) highRun++;
      if (!casN || !rasN) chk(strobeOwn, "R9 own while strobing", strobeOwn, 1);

      if (initDone && t0 == 0) t0 = n;
      tick = (t0 != 0) && (n > t0) && (((n - t0) % I) == 0);
      dec  = (decEdge == n);
      if (tick && !dec) expOwed = satInc(expOwed);
      else if (dec && !tick) expOwed = expOwed - 1;
      if (initDone) begin
        chk(refUrgent == (expOwed == M), "R8/R10 urgent vs owed", refUrgent, int'(expOwed == M));
        chk(refReq == (expOwed != 0 && !strobeOwn), "R6 request vs owed", refReq,
            int'(expOwed != 0 && !strobeOwn));
      end

      if (reqAtEdge && grantAtEdge)
        chk(!casN && strobeOwn, "R7 grant starts cycle", casN, 0);
      if (!reqAtEdge && !ownAtEdge && grantAtEdge)
        chk(casN && !strobeOwn, "R7 grant without request ignored", casN, 1);

      prevRas = rasN;
      prevCas = casN;
    end
  end

  task automatic waitEdge(input int target);
    while (n < target) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(rasN && casN && weN, "R1 strobes high in reset", {rasN, casN, weN}, 7);
    chk(strobeOwn == 1'b1, "R1 own in reset", strobeOwn, 1);
    chk(!initDone && !refReq && !refUrgent, "R1 flags low in reset",
        {initDone, refReq, refUrgent}, 0);
    rstN = 1'b1;

    // R2 pause length
    waitEdge(P - 1);
    chk(casN == 1'b1, "R2 cas high before pause end", casN, 1);
    @(negedge clk);
    chk(casN == 1'b0, "R2 cas falls at pause end", casN, 0);

    // R3 wake sequence
    waitEdge(T0 - 1);
    chk(initDone == 1'b0, "R3 init low before last precharge ends", initDone, 0);
    @(negedge clk);
    chk(initDone == 1'b1, "R3 init high after wake", initDone, 1);
    chk(cbrCount == W, "R3 wake cycle count", cbrCount, W);

    // R7 grant with nothing owed
    waitEdge(T0 + 5);
    refGrant = 1'b1;
    @(negedge clk);
    refGrant = 1'b0;
    @(negedge clk);
    chk(casN && !strobeOwn, "R7 stray grant left idle", casN, 1);

    // R6 first interval
    waitEdge(T0 + I - 1);
    chk(refReq == 1'b0, "R6 no request before first interval", refReq, 0);
    @(negedge clk);
    chk(refReq == 1'b1, "R6 request after first interval", refReq, 1);
    refGrant = 1'b1;
    @(negedge clk);
    refGrant = 1'b0;
    chk(!casN && strobeOwn, "R7 cycle starts after grant", casN, 0);

    // R8 starvation then drain
    repeat (I * (M + 2)) @(negedge clk);
    chk(refUrgent == 1'b1, "R8 urgent after starvation", refUrgent, 1);
    refGrant = 1'b1;
    begin
      int guard = 0;
      @(negedge clk);
      while ((refReq || strobeOwn) && guard < 3000) begin
        @(negedge clk);
        guard++;
      end
      chk(guard < 3000, "R8 backlog drained", guard, 0);
    end
    refGrant = 1'b0;

    // Random grant patterns
    for (int s = 0; s < 40; s++) begin
      int mode = $urandom % 3;
      int len = $urandom_range(20, 600);
      for (int j = 0; j < len; j++) begin
        @(negedge clk);
        refGrant = (mode == 0) ? 1'b0 : (mode == 1) ? 1'b1 : 1'($urandom % 2);
      end
    end
    refGrant = 1'b0;
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: run did not complete, got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule